// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block sits beside one processor's snooping cache and tracks a single line reservation for a load-reserved / store-conditional instruction pair. When the core issues a reserve load, the monitor records the line address and sets a valid flag. It then asks the cache controller for the line with an ordinary shared read.

When the core issues a conditional store, the monitor checks two things: the reservation must still be valid, and its line must match the store's line. If both hold, it tells the cache controller to request exclusive ownership, and it reports success to the core. Otherwise it reports failure and issues nothing.

The reservation is dropped in three cases: another agent's write-ownership request for the reserved line is snooped, the line leaves the local cache, or any conditional store is made. The bus sees only ordinary shared and exclusive requests. No atomic transaction type is involved.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset the reservation is invalid, and `cc_req_valid` and `core_rsp_valid` are 0.
- R2: A reserve load (`core_req_kind`=0) accepted in cycle N produces, in cycle N+1, `cc_req_valid`=1 with `cc_req_excl`=0 (shared read) and `cc_req_line` equal to the request's line address. It produces no core response.
- R3: A reserve load always overwrites any earlier reservation with its own line and sets the valid flag.
- R4: A conditional store (`core_req_kind`=1) in cycle N that finds a valid reservation for the same line succeeds. In cycle N+1 it gives `core_rsp_valid`=1 and `core_rsp_fail`=0, together with `cc_req_valid`=1, `cc_req_excl`=1 and that line.
- R5: A conditional store that finds no valid reservation, or a reservation for another line, gives `core_rsp_valid`=1 and `core_rsp_fail`=1 in cycle N+1, with `cc_req_valid`=0.
- R6: Every conditional store, whether it succeeds or fails, ends the reservation, so a following conditional store without a new reserve load fails.
- R7: A snooped request from another agent with `snp_excl`=1 for the reserved line clears the reservation. A snooped shared request (`snp_excl`=0) does not clear it, and neither does an exclusive request for another line.
- R8: A local eviction or invalidation (`loc_drop_valid`=1) of the reserved line clears the reservation. A local drop of another line does not clear it.
- R9: Addresses are compared per line. The low `LINE_OFF_W` bits (default 5) of `core_req_addr` are ignored, and the line address is `core_req_addr[ADDR_W-1:LINE_OFF_W]`.
- R10: A clearing event (R7 or R8) for the reserved line in the same cycle as a conditional store takes effect first, so the store fails.
- R11: A reserve load in the same cycle as a clearing event for the same line leaves a valid reservation, so a later conditional store to that line succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core issues a reserve load or conditional store |
| core_req_kind | input | 1 | 0 = reserve load, 1 = conditional store |
| core_req_addr | input | ADDR_W | Byte address of the request |
| snp_valid | input | 1 | Snooped request from another agent |
| snp_excl | input | 1 | Snooped request asks for write ownership |
| snp_line | input | ADDR_W-LINE_OFF_W | Line address of the snooped request |
| loc_drop_valid | input | 1 | A line leaves the local cache (eviction or invalidation) |
| loc_drop_line | input | ADDR_W-LINE_OFF_W | Line address that leaves |
| cc_req_valid | output | 1 | Coherence request to the cache controller |
| cc_req_excl | output | 1 | 1 = exclusive (write) request, 0 = shared (read) request |
| cc_req_line | output | ADDR_W-LINE_OFF_W | Line address of the coherence request |
| core_rsp_valid | output | 1 | Conditional store result is valid |
| core_rsp_fail | output | 1 | 1 = conditional store failed, 0 = succeeded |

## Verification
The two functions that can meet in one cycle are the conditional-store decision and the clearing of the reservation by a snoop or a local drop. The same collision applies to a reserve load. The bench drives a conditional store and an exclusive snoop or local drop for the reserved line in one cycle, and expects a failure. It also drives a reserve load together with a clearing event for that line, and expects a later store to succeed. Random traffic over a pool of four lines produces further collisions, and every cycle's outputs are compared against a bench model that applies clearing before the store decision.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic {
    KIND_RESERVE = 1'b0,
    KIND_CSTORE  = 1'b1
  } core_kind_e;

  localparam int unsigned NUM_KILL_SRC = 2;
  localparam int unsigned KSRC_SNOOP   = 0;
  localparam int unsigned KSRC_DROP    = 1;
endpackage

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
  parameter int unsigned TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  output logic             resv_valid,
  output logic [TAG_W-1:0] resv_tag
);
  logic valid_d;
  logic tag_en;

  always_comb begin
    valid_d = resv_valid;
    if (set_en)      valid_d = 1'b1;
    else if (clr_en) valid_d = 1'b0;
    tag_en = set_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resv_valid <= 1'b0;
    else        resv_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      resv_tag <= '0;
    else if (tag_en) resv_tag <= set_tag;
  end
endmodule

// File: rtl/lrsc_kill_detect.sv
module lrsc_kill_detect #(
  parameter int unsigned TAG_W = 27,
  parameter int unsigned NSRC  = 2
) (
  input  logic [NSRC-1:0]           src_valid,
  input  logic [NSRC-1:0][TAG_W-1:0] src_line,
  input  logic [TAG_W-1:0]          resv_tag,
  output logic                      kill
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = src_valid[g] && (src_line[g] == resv_tag);
  end

  assign kill = |hit;
endmodule

// File: rtl/lrsc_sc_judge.sv
module lrsc_sc_judge #(
  parameter int unsigned TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lr_req,
  input  logic             sc_req,
  input  logic [TAG_W-1:0] req_line,
  input  logic             resv_valid,
  input  logic [TAG_W-1:0] resv_tag,
  input  logic             kill,
  output logic             cc_req_valid,
  output logic             cc_req_excl,
  output logic [TAG_W-1:0] cc_req_line,
  output logic             core_rsp_valid,
  output logic             core_rsp_fail
);
  logic             sc_ok;
  logic             cc_v_d, cc_x_d, rsp_v_d, rsp_f_d;
  logic             line_en;

  always_comb begin
    sc_ok   = sc_req && resv_valid && (resv_tag == req_line) && !kill;
    cc_v_d  = lr_req || sc_ok;
    cc_x_d  = sc_ok;
    rsp_v_d = sc_req;
    rsp_f_d = sc_req && !sc_ok;
    line_en = cc_v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_req_valid   <= 1'b0;
      cc_req_excl    <= 1'b0;
      core_rsp_valid <= 1'b0;
      core_rsp_fail  <= 1'b0;
    end else begin
      cc_req_valid   <= cc_v_d;
      cc_req_excl    <= cc_x_d;
      core_rsp_valid <= rsp_v_d;
      core_rsp_fail  <= rsp_f_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cc_req_line <= '0;
    else if (line_en) cc_req_line <= req_line;
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_OFF_W = 5,
  localparam int unsigned TAG_W     = ADDR_W - LINE_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req_valid,
  input  logic              core_req_kind,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic              snp_valid,
  input  logic              snp_excl,
  input  logic [TAG_W-1:0]  snp_line,
  input  logic              loc_drop_valid,
  input  logic [TAG_W-1:0]  loc_drop_line,
  output logic              cc_req_valid,
  output logic              cc_req_excl,
  output logic [TAG_W-1:0]  cc_req_line,
  output logic              core_rsp_valid,
  output logic              core_rsp_fail
);
  import lrsc_pkg::*;

  logic                               lr_req, sc_req;
  logic [TAG_W-1:0]                   req_line;
  logic                               resv_valid;
  logic [TAG_W-1:0]                   resv_tag;
  logic                               kill;
  logic [NUM_KILL_SRC-1:0]            ksrc_valid;
  logic [NUM_KILL_SRC-1:0][TAG_W-1:0] ksrc_line;

  always_comb begin
    lr_req   = core_req_valid && (core_kind_e'(core_req_kind) == KIND_RESERVE);
    sc_req   = core_req_valid && (core_kind_e'(core_req_kind) == KIND_CSTORE);
    req_line = core_req_addr[ADDR_W-1:LINE_OFF_W];
    ksrc_valid[KSRC_SNOOP] = snp_valid && snp_excl;
    ksrc_line[KSRC_SNOOP]  = snp_line;
    ksrc_valid[KSRC_DROP]  = loc_drop_valid;
    ksrc_line[KSRC_DROP]   = loc_drop_line;
  end

  lrsc_kill_detect #(.TAG_W(TAG_W), .NSRC(NUM_KILL_SRC)) u_kill (
    .src_valid (ksrc_valid),
    .src_line  (ksrc_line),
    .resv_tag  (resv_tag),
    .kill      (kill)
  );

  lrsc_resv_reg #(.TAG_W(TAG_W)) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (lr_req),
    .set_tag    (req_line),
    .clr_en     (kill || sc_req),
    .resv_valid (resv_valid),
    .resv_tag   (resv_tag)
  );

  lrsc_sc_judge #(.TAG_W(TAG_W)) u_judge (
    .clk            (clk),
    .rst_n          (rst_n),
    .lr_req         (lr_req),
    .sc_req         (sc_req),
    .req_line       (req_line),
    .resv_valid     (resv_valid),
    .resv_tag       (resv_tag),
    .kill           (kill),
    .cc_req_valid   (cc_req_valid),
    .cc_req_excl    (cc_req_excl),
    .cc_req_line    (cc_req_line),
    .core_rsp_valid (core_rsp_valid),
    .core_rsp_fail  (core_rsp_fail)
  );
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_OFF_W = 5,
  localparam int unsigned TAG_W     = ADDR_W - LINE_OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req_valid,
  input logic              core_req_kind,
  input logic [ADDR_W-1:0] core_req_addr,
  input logic              snp_valid,
  input logic              snp_excl,
  input logic [TAG_W-1:0]  snp_line,
  input logic              cc_req_valid,
  input logic              cc_req_excl,
  input logic              core_rsp_valid,
  input logic              core_rsp_fail
);
  logic lr_in, sc_in, snp_kill_same;
  assign lr_in = core_req_valid && !core_req_kind;
  assign sc_in = core_req_valid && core_req_kind;
  assign snp_kill_same = snp_valid && snp_excl &&
                         (snp_line == core_req_addr[ADDR_W-1:LINE_OFF_W]);

  a_r2_reserve_shared: assert property (@(posedge clk) disable iff (!rst_n)
    lr_in |=> (cc_req_valid && !cc_req_excl && !core_rsp_valid));

  a_r4_excl_only_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_req_valid && cc_req_excl) |-> (core_rsp_valid && !core_rsp_fail));

  a_r5_fail_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rsp_valid && core_rsp_fail) |-> !cc_req_valid);

  a_r6_back_to_back_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_in ##1 sc_in) |=> core_rsp_fail);

  a_r10_snoop_beats_store: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_in && snp_kill_same) |=> (core_rsp_valid && core_rsp_fail));
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_req_valid (core_req_valid),
  .core_req_kind  (core_req_kind),
  .core_req_addr  (core_req_addr),
  .snp_valid      (snp_valid),
  .snp_excl       (snp_excl),
  .snp_line       (snp_line),
  .cc_req_valid   (cc_req_valid),
  .cc_req_excl    (cc_req_excl),
  .core_rsp_valid (core_rsp_valid),
  .core_rsp_fail  (core_rsp_fail)
);

// File: tb/lrsc_monitor_tb_top.sv
`timescale 1ns/1ps
module lrsc_monitor_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned OFF_W  = 5;
  localparam int unsigned TAG_W  = ADDR_W - OFF_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              core_req_valid = 1'b0;
  logic              core_req_kind = 1'b0;
  logic [ADDR_W-1:0] core_req_addr = '0;
  logic              snp_valid = 1'b0;
  logic              snp_excl = 1'b0;
  logic [TAG_W-1:0]  snp_line = '0;
  logic              loc_drop_valid = 1'b0;
  logic [TAG_W-1:0]  loc_drop_line = '0;
  logic              cc_req_valid, cc_req_excl, core_rsp_valid, core_rsp_fail;
  logic [TAG_W-1:0]  cc_req_line;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;

  bit               m_valid = 1'b0;
  logic [TAG_W-1:0] m_tag = '0;

  always #2 clk = ~clk;

  lrsc_monitor #(.ADDR_W(ADDR_W), .LINE_OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(core_req_valid), .core_req_kind(core_req_kind),
    .core_req_addr(core_req_addr),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_line(snp_line),
    .loc_drop_valid(loc_drop_valid), .loc_drop_line(loc_drop_line),
    .cc_req_valid(cc_req_valid), .cc_req_excl(cc_req_excl), .cc_req_line(cc_req_line),
    .core_rsp_valid(core_rsp_valid), .core_rsp_fail(core_rsp_fail)
  );

  function automatic logic [ADDR_W-1:0] mk_addr(input int unsigned line, input int unsigned off);
    return {TAG_W'(line), OFF_W'(off)};
  endfunction

  function automatic bit kill_hit(input bit sv, input bit sx, input logic [TAG_W-1:0] sl,
                                  input bit dv, input logic [TAG_W-1:0] dl);
    return (sv && sx && sl == m_tag) || (dv && dl == m_tag);
  endfunction

  task automatic cmp(input string tag, input logic [TAG_W+3:0] act, input logic [TAG_W+3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model, check outputs at next negedge
  task automatic step(input string tag, input bit cv, input bit ck, input logic [ADDR_W-1:0] ca,
                      input bit sv, input bit sx, input logic [TAG_W-1:0] sl,
                      input bit dv, input logic [TAG_W-1:0] dl);
    logic [TAG_W-1:0] line;
    bit lr, sc, kl, ok;
    logic [TAG_W+3:0] exp;
    core_req_valid = cv; core_req_kind = ck; core_req_addr = ca;
    snp_valid = sv; snp_excl = sx; snp_line = sl;
    loc_drop_valid = dv; loc_drop_line = dl;
    line = ca[ADDR_W-1:OFF_W];
    lr = cv && !ck;
    sc = cv && ck;
    kl = kill_hit(sv, sx, sl, dv, dl);
    ok = sc && m_valid && (m_tag == line) && !kl;
    if (lr) begin m_valid = 1'b1; m_tag = line; end
    else if (kl || sc) m_valid = 1'b0;
    @(negedge clk);
    exp = {(lr || ok), ok, ((lr || ok) ? line : cc_req_line), sc, (sc && !ok)};
    cmp(tag, {cc_req_valid, cc_req_excl, cc_req_line, core_rsp_valid, core_rsp_fail}, exp);
  endtask

  task automatic idle();
    step("idle", 0, 0, '0, 0, 0, '0, 0, '0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    cmp("R1", {cc_req_valid, 1'b0, TAG_W'(0), core_rsp_valid, 1'b0}, '0);
    step("R1 store without reservation", 1, 1, mk_addr(3, 0), 0, 0, '0, 0, '0);

    // R2 / R4: reserve then store succeeds
    step("R2", 1, 0, mk_addr(10, 4), 0, 0, '0, 0, '0);
    step("R4", 1, 1, mk_addr(10, 4), 0, 0, '0, 0, '0);
    // R6: store again fails
    step("R6", 1, 1, mk_addr(10, 4), 0, 0, '0, 0, '0);

    // R7: shared snoop and other-line exclusive keep reservation
    step("R2", 1, 0, mk_addr(11, 0), 0, 0, '0, 0, '0);
    step("R7 shared", 0, 0, '0, 1, 0, TAG_W'(11), 0, '0);
    step("R7 other line", 0, 0, '0, 1, 1, TAG_W'(12), 0, '0);
    step("R7 survive", 1, 1, mk_addr(11, 0), 0, 0, '0, 0, '0);
    // R7: exclusive snoop same line clears
    step("R2", 1, 0, mk_addr(11, 0), 0, 0, '0, 0, '0);
    step("R7 kill", 0, 0, '0, 1, 1, TAG_W'(11), 0, '0);
    step("R7 after kill", 1, 1, mk_addr(11, 0), 0, 0, '0, 0, '0);

    // R8: local drop
    step("R2", 1, 0, mk_addr(20, 0), 0, 0, '0, 0, '0);
    step("R8 other drop", 0, 0, '0, 0, 0, '0, 1, TAG_W'(21));
    step("R8 drop same", 0, 0, '0, 0, 0, '0, 1, TAG_W'(20));
    step("R8 after drop", 1, 1, mk_addr(20, 0), 0, 0, '0, 0, '0);

    // R3: overwrite
    step("R3 first", 1, 0, mk_addr(30, 0), 0, 0, '0, 0, '0);
    step("R3 second", 1, 0, mk_addr(31, 0), 0, 0, '0, 0, '0);
    step("R3 old line", 1, 1, mk_addr(30, 0), 0, 0, '0, 0, '0);
    step("R3 new", 1, 0, mk_addr(31, 0), 0, 0, '0, 0, '0);
    step("R3 new line", 1, 1, mk_addr(31, 0), 0, 0, '0, 0, '0);

    // R9: offsets ignored
    step("R9 reserve", 1, 0, mk_addr(40, 3), 0, 0, '0, 0, '0);
    step("R9 store", 1, 1, mk_addr(40, 29), 0, 0, '0, 0, '0);

    // R5: mismatching line
    step("R5 reserve", 1, 0, mk_addr(41, 0), 0, 0, '0, 0, '0);
    step("R5 mismatch", 1, 1, mk_addr(42, 0), 0, 0, '0, 0, '0);

    // R10: collision of store and kill
    step("R10 reserve", 1, 0, mk_addr(50, 0), 0, 0, '0, 0, '0);
    step("R10 snoop", 1, 1, mk_addr(50, 0), 1, 1, TAG_W'(50), 0, '0);
    step("R10 reserve", 1, 0, mk_addr(50, 0), 0, 0, '0, 0, '0);
    step("R10 drop", 1, 1, mk_addr(50, 0), 0, 0, '0, 1, TAG_W'(50));

    // R11: reserve with same-cycle kill
    step("R11 reserve", 1, 0, mk_addr(60, 0), 0, 0, '0, 0, '0);
    step("R11 reserve+kill", 1, 0, mk_addr(60, 0), 1, 1, TAG_W'(60), 1, TAG_W'(60));
    step("R11 store", 1, 1, mk_addr(60, 0), 0, 0, '0, 0, '0);
    idle();

    // random traffic over four lines
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom_range(0, 9);
      step("R4/R5/R7/R8 random", r < 7, r >= 4,
           mk_addr($urandom_range(0, 3), $urandom_range(0, 31)),
           $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, TAG_W'($urandom_range(0, 3)),
           $urandom_range(0, 4) == 0, TAG_W'($urandom_range(0, 3)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule